// File: doc/BRIEF.md
# Fringe Stopping Phase Rotator

This block takes a stream of one-bit samples from a single station and removes a linearly varying phase from it before spectral analysis. Each accepted bit becomes a signed 16-bit level of plus or minus a quarter of full scale. That level is multiplied by a unit phasor taken from a sine/cosine table. A 32-bit phase accumulator addresses the table, and its rate and starting phase come from a parameter load port.

The rotated complex samples are collected into one of two frame banks. When a bank holds a full frame, the banks swap and a one-cycle ready pulse is issued. A downstream transform engine then reads the filled bank through a synchronous read port while the next frame fills the other bank. The phase model stays fixed for a whole model period of several frames. New parameters can be loaded at any time, but they only take effect at the first sample of the next model period.

Top module: `fringe_rotator`

## Requirements
- R1: An input bit of 1 enters the rotation as the 16-bit level 0x4000 (+16384), and a bit of 0 enters as 0xC000 (-16384).
- R2: The k-th accepted sample of a model period (k counted from 0) uses phase P = phase0 + k*rate modulo 2^32. The table angle is 2*pi*(P[31:18]+0.5)/16384, taken from the top 14 bits.
- R3: The sine and cosine values are 16-bit signed numbers equal to round(32767*sin) and round(32767*cos) of that angle. They are served from one quarter-wave table by quadrant folding.
- R4: With x the level from R1, c the cosine and s the sine, each stored word has the real part in bits 31:16 equal to round(x*c/2^15) and the imaginary part in bits 15:0 equal to round(-x*s/2^15). Both parts are saturated to 16 bits.
- R5: Cycles with in_valid low do not advance the phase or the position in the frame or in the model period.
- R6: A parameter load (prm_load high) stores rate and phase0. The stored pair becomes the active model only at the first sample of the next model period, which starts every MODEL_FRAMES frames. A load in the middle of a period leaves the rest of that period unchanged.
- R7: Sample j of a frame (j from 0) is stored at address j of the current write bank. After the last entry the banks swap, and rd_addr reads the bank just filled while the next frame is written to the other bank.
- R8: frame_ready is high for exactly one cycle, in the cycle that follows the third rising edge after the edge that accepts a frame's last sample. It is low at all other times.
- R9: rd_data shows the word at rd_addr one rising edge after rd_addr is presented.
- R10: While rst_n is low, frame_ready and rd_data are held at 0.
- R11: Every stored real and imaginary value lies within -16384 to +16384.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Sample strobe |
| in_bit | input | 1 | One-bit station sample |
| prm_load | input | 1 | Store new phase model parameters |
| prm_rate | input | ACC_W | Phase increment per sample |
| prm_phase | input | ACC_W | Phase at the first sample of a model period |
| rd_addr | input | FRAME_AW | Read address within the filled bank |
| frame_ready | output | 1 | One-cycle pulse when a bank has filled |
| rd_data | output | 32 | Stored word {real, imaginary} |

## Verification
The bench builds the block with FRAME_AW=4 and MODEL_FRAMES=4, so a frame has 16 samples and a model period has 64. It keeps the 32-bit accumulator and the 14-bit table phase at their full size. The short frames and periods make hundreds of bank swaps and model reloads reachable within a short run. A unit-step rate then walks the phase across all 16384 table addresses, once with each sample polarity drawn at random. A second phase uses random rates, random idle gaps, mid-period parameter loads and reads of a bank while the other bank fills.

// File: rtl/fringe_pkg.sv
// Shared sample types, input levels and the round/saturate helper for the
// fringe rotator. Assumes 16-bit signed sample arithmetic throughout.
package fringe_pkg;

    localparam int SMP_W  = 16;
    localparam int WIDE_W = 2 * SMP_W + 1;

    typedef logic signed [SMP_W-1:0]  smp_t;
    typedef logic signed [WIDE_W-1:0] wide_t;

    typedef struct packed {
        smp_t re;
        smp_t im;
    } cplx_t;

    localparam smp_t  LEVEL_ONE  = 16'sh4000;
    localparam smp_t  LEVEL_ZERO = 16'shC000;
    localparam wide_t SAT_HI     = wide_t'((1 <<< (SMP_W - 1)) - 1);
    localparam wide_t SAT_LO     = -wide_t'(1 <<< (SMP_W - 1));
    localparam wide_t HALF_LSB   = wide_t'(1 <<< (SMP_W - 2));

    // Scale a full product back by 2^(SMP_W-1), rounding half up, then clamp.
    function automatic smp_t shrink(input wide_t prod);
        wide_t r;
        r = (prod + HALF_LSB) >>> (SMP_W - 1);
        if (r > SAT_HI) begin
            return SAT_HI[SMP_W-1:0];
        end else if (r < SAT_LO) begin
            return SAT_LO[SMP_W-1:0];
        end
        return r[SMP_W-1:0];
    endfunction

endpackage

// File: rtl/fr_phase_gen.sv
// Linear phase model: a staged rate/phase pair is taken over at the first
// sample of each model period; the accumulator then steps by the rate once per
// valid sample. Emits the top PHASE_W bits one cycle after the sample.
// Assumes MODEL_LEN >= 2.
module fr_phase_gen #(
    parameter int ACC_W     = 32,
    parameter int PHASE_W   = 14,
    parameter int MODEL_LEN = 163840
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               prm_load,
    input  logic [ACC_W-1:0]   prm_rate,
    input  logic [ACC_W-1:0]   prm_phase,
    input  logic               in_valid,
    output logic               out_valid,
    output logic [PHASE_W-1:0] out_phase
);

    localparam int             CNT_W    = (MODEL_LEN > 1) ? $clog2(MODEL_LEN) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(MODEL_LEN - 1);

    logic [ACC_W-1:0] stg_rate, stg_phase, act_rate, acc;
    logic [ACC_W-1:0] ph_now, rate_now;
    logic [CNT_W-1:0] cnt;

    // Pick the staged model at a period start, otherwise the running one.
    always_comb begin
        ph_now   = (cnt == '0) ? stg_phase : acc;
        rate_now = (cnt == '0) ? stg_rate  : act_rate;
    end

    // Hold the most recently loaded parameter pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_rate  <= '0;
            stg_phase <= '0;
        end else if (prm_load) begin
            stg_rate  <= prm_rate;
            stg_phase <= prm_phase;
        end
    end

    // Advance the accumulator and period position on each accepted sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc      <= '0;
            act_rate <= '0;
            cnt      <= '0;
        end else if (in_valid) begin
            acc      <= ph_now + rate_now;
            act_rate <= rate_now;
            cnt      <= (cnt == CNT_LAST) ? '0 : cnt + CNT_W'(1);
        end
    end

    // Register the table phase for the sample just accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_phase <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_phase <= ph_now[ACC_W-1 -: PHASE_W];
            end
        end
    end

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(acc) && $stable(cnt))); // R5

    AST_RELOAD_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cnt == '0) |=> (act_rate == $past(stg_rate))); // R6

endmodule

// File: rtl/fr_sincos.sv
// Sine/cosine generator: one quarter-wave magnitude table, built at elaboration
// from an integer series, is folded by quadrant into both outputs. Angles sit
// half a step off zero so the mirrored index is the bitwise complement.
// One cycle of latency. Assumes PHASE_W >= 3.
module fr_sincos #(
    parameter int PHASE_W = 14,
    parameter int AMP_W   = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [PHASE_W-1:0]       in_phase,
    output logic                     out_valid,
    output logic signed [AMP_W-1:0]  out_sin,
    output logic signed [AMP_W-1:0]  out_cos
);

    localparam int     QTR_W  = PHASE_W - 2;
    localparam int     QTR_N  = 1 << QTR_W;
    localparam int     MAG_W  = AMP_W - 1;
    localparam longint AMP    = (longint'(1) <<< MAG_W) - 1;
    localparam longint PI_Q30 = 64'sd3373259426;

    // Table entry k: AMP*sin(pi*(2k+1)/2^PHASE_W) by a Taylor series in Q30.
    function automatic logic [MAG_W-1:0] quarter_sine(input int k);
        longint x, x2, term, sum;
        x    = ((2 * longint'(k) + 1) * PI_Q30) >>> PHASE_W;
        x2   = (x * x) >>> 30;
        term = x;
        sum  = x;
        for (int n = 1; n <= 8; n++) begin
            term = -((term * x2) >>> 30) / longint'(2 * n * (2 * n + 1));
            sum  = sum + term;
        end
        sum = (sum * AMP + (longint'(1) <<< 29)) >>> 30;
        if (sum > AMP) sum = AMP;
        if (sum < 0)   sum = 0;
        return sum[MAG_W-1:0];
    endfunction

    logic [MAG_W-1:0] qrom [QTR_N];

    for (genvar g = 0; g < QTR_N; g++) begin : g_rom
        localparam logic [MAG_W-1:0] ENTRY = quarter_sine(g);
        assign qrom[g] = ENTRY;
    end

    logic [1:0]       quad;
    logic [QTR_W-1:0] idx;
    logic [MAG_W-1:0] sin_mag, cos_mag;
    logic             sin_neg, cos_neg;
    logic signed [AMP_W-1:0] sin_v, cos_v;

    // Fold the quadrant: choose direct or mirrored magnitude and the signs.
    always_comb begin
        quad    = in_phase[PHASE_W-1 -: 2];
        idx     = in_phase[QTR_W-1:0];
        sin_mag = quad[0] ? qrom[~idx] : qrom[idx];
        cos_mag = quad[0] ? qrom[idx]  : qrom[~idx];
        sin_neg = quad[1];
        cos_neg = quad[1] ^ quad[0];
        sin_v   = sin_neg ? -$signed({1'b0, sin_mag}) : $signed({1'b0, sin_mag});
        cos_v   = cos_neg ? -$signed({1'b0, cos_mag}) : $signed({1'b0, cos_mag});
    end

    // Register the phasor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_sin   <= '0;
            out_cos   <= '0;
        end else begin
            out_valid <= in_valid;
            out_sin   <= sin_v;
            out_cos   <= cos_v;
        end
    end

    longint norm;
    assign norm = longint'(out_sin) * longint'(out_sin) + longint'(out_cos) * longint'(out_cos);

    AST_UNIT_CIRCLE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (norm >= AMP * AMP - 3 * AMP && norm <= AMP * AMP + 3 * AMP)); // R3

endmodule

// File: rtl/fr_frame_buf.sv
// Two-bank frame store: writes fill the current bank in address order, the
// last write swaps banks and pulses frame_ready; the read port serves the
// other (filled) bank with one cycle of latency. Assumes AW >= 1.
module fr_frame_buf #(
    parameter int AW = 10,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic          frame_ready
);

    localparam int            DEPTH    = 1 << (AW + 1);
    localparam logic [AW-1:0] PTR_LAST = '1;

    logic [DW-1:0] mem [DEPTH];
    logic          wr_bank;
    logic [AW-1:0] wr_ptr;

    // Track the write position, swap banks and flag a full frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_bank     <= 1'b0;
            wr_ptr      <= '0;
            frame_ready <= 1'b0;
        end else begin
            frame_ready <= 1'b0;
            if (wr_en) begin
                wr_ptr <= wr_ptr + AW'(1);
                if (wr_ptr == PTR_LAST) begin
                    wr_bank     <= ~wr_bank;
                    frame_ready <= 1'b1;
                end
            end
        end
    end

    // Store the incoming word in the active bank.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[{wr_bank, wr_ptr}] <= wr_data;
        end
    end

    // Read the filled bank.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else begin
            rd_data <= mem[{~wr_bank, rd_addr}];
        end
    end

    AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_ready |=> !frame_ready); // R8

    AST_READY_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        frame_ready |-> (wr_ptr == '0)); // R7

endmodule

// File: rtl/fringe_rotator.sv
// Fringe stopping rotator top: maps one-bit samples to +/-0x4000, multiplies by
// the conjugate of the model phasor, rounds back to 16 bits and stores the
// result in a ping-pong frame buffer. Pipeline: phase (1) -> phasor (2) ->
// rotate (3) -> write/ready (4). Assumes FRAME_AW >= 1 and MODEL_FRAMES >= 1.
module fringe_rotator
    import fringe_pkg::*;
#(
    parameter int FRAME_AW     = 10,
    parameter int MODEL_FRAMES = 160,
    parameter int ACC_W        = 32,
    parameter int PHASE_W      = 14
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic                 in_bit,
    input  logic                 prm_load,
    input  logic [ACC_W-1:0]     prm_rate,
    input  logic [ACC_W-1:0]     prm_phase,
    input  logic [FRAME_AW-1:0]  rd_addr,
    output logic                 frame_ready,
    output logic [2*SMP_W-1:0]   rd_data
);

    localparam int MODEL_LEN = MODEL_FRAMES << FRAME_AW;

    logic               v1, v2, v3;
    logic [PHASE_W-1:0] ph1;
    smp_t               sin2, cos2;
    logic               b1, b2;
    smp_t               x2;
    wide_t              re_p, im_p;
    cplx_t              s3;

    fr_phase_gen #(
        .ACC_W     (ACC_W),
        .PHASE_W   (PHASE_W),
        .MODEL_LEN (MODEL_LEN)
    ) u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .prm_load  (prm_load),
        .prm_rate  (prm_rate),
        .prm_phase (prm_phase),
        .in_valid  (in_valid),
        .out_valid (v1),
        .out_phase (ph1)
    );

    fr_sincos #(
        .PHASE_W (PHASE_W),
        .AMP_W   (SMP_W)
    ) u_sincos (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (v1),
        .in_phase  (ph1),
        .out_valid (v2),
        .out_sin   (sin2),
        .out_cos   (cos2)
    );

    // Carry the sample bit alongside the phase and phasor stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b1 <= 1'b0;
            b2 <= 1'b0;
        end else begin
            if (in_valid) begin
                b1 <= in_bit;
            end
            b2 <= b1;
        end
    end

    // Map the bit to its level and form the full-width conjugate products.
    always_comb begin
        x2   = b2 ? LEVEL_ONE : LEVEL_ZERO;
        re_p = wide_t'(x2) * wide_t'(cos2);
        im_p = -(wide_t'(x2) * wide_t'(sin2));
    end

    // Round, saturate and register the rotated sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v3 <= 1'b0;
            s3 <= '0;
        end else begin
            v3    <= v2;
            s3.re <= shrink(re_p);
            s3.im <= shrink(im_p);
        end
    end

    fr_frame_buf #(
        .AW (FRAME_AW),
        .DW (2 * SMP_W)
    ) u_buf (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (v3),
        .wr_data     (s3),
        .rd_addr     (rd_addr),
        .rd_data     (rd_data),
        .frame_ready (frame_ready)
    );

    AST_HEADROOM: assert property (@(posedge clk) disable iff (!rst_n)
        v3 |-> (s3.re >= -16'sd16384 && s3.re <= 16'sd16384 &&
                s3.im >= -16'sd16384 && s3.im <= 16'sd16384)); // R11

endmodule

// File: tb/fringe_rotator_tb_top.sv
// Bench: 16-sample frames, 64-sample model periods, full 14-bit phase table.
// Sweep A walks every table address with a unit rate; sweep B uses random
// rates, idle gaps, mid-period loads and reads overlapping the next frame.
module fringe_rotator_tb_top;

    localparam int FAW  = 4;
    localparam int FLEN = 1 << FAW;
    localparam int MF   = 4;
    localparam int MLEN = MF * FLEN;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic            in_bit = 1'b0;
    logic            prm_load = 1'b0;
    logic [31:0]     prm_rate = '0;
    logic [31:0]     prm_phase = '0;
    logic [FAW-1:0]  rd_addr = '0;
    logic            frame_ready;
    logic [31:0]     rd_data;

    always #4 clk = ~clk;

    fringe_rotator #(
        .FRAME_AW     (FAW),
        .MODEL_FRAMES (MF),
        .ACC_W        (32),
        .PHASE_W      (14)
    ) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_bit      (in_bit),
        .prm_load    (prm_load),
        .prm_rate    (prm_rate),
        .prm_phase   (prm_phase),
        .rd_addr     (rd_addr),
        .frame_ready (frame_ready),
        .rd_data     (rd_data)
    );

    int checks = 0;
    int fails  = 0;

    logic [31:0] stg_rate = '0, stg_ph = '0, m_rate = '0, m_ph = '0;
    int m_cnt = 0;
    int fill_idx = 0;
    int fill_re [FLEN];
    int fill_im [FLEN];
    int done_re [FLEN];
    int done_im [FLEN];
    logic last_flag = 1'b0;
    logic [3:0] rdy_pipe = '0;

    // R8: ready expected three edges after the edge taking a frame's last sample.
    always @(posedge clk) rdy_pipe <= {rdy_pipe[2:0], in_valid & last_flag};

    always @(negedge clk) begin
        if (rst_n && (rdy_pipe[3] || frame_ready)) begin
            checks++;
            if (frame_ready !== rdy_pipe[3]) begin
                fails++;
                $display("FAIL R8 frame_ready actual=%b expected=%b", frame_ready, rdy_pipe[3]);
            end
        end
    end

    // Expected rotated sample from R1..R4.
    function automatic void expect_of(input logic [31:0] ph, input bit b,
                                      output int re, output int im);
        int     idx;
        real    th;
        int     c, s;
        longint x;
        idx = int'(ph[31:18]);
        th  = 2.0 * 3.14159265358979 * (real'(idx) + 0.5) / 16384.0;
        c   = int'(32767.0 * $cos(th));
        s   = int'(32767.0 * $sin(th));
        x   = b ? 64'sd16384 : -64'sd16384;
        re  = int'((x * c + 16384) >>> 15);
        im  = int'((-(x * s) + 16384) >>> 15);
    endfunction

    task automatic step();
        @(negedge clk);
        in_valid  = 1'b0;
        last_flag = 1'b0;
        prm_load  = 1'b0;
    endtask

    task automatic load(input logic [31:0] rate, input logic [31:0] ph);
        step();
        prm_load  = 1'b1;
        prm_rate  = rate;
        prm_phase = ph;
        stg_rate  = rate;
        stg_ph    = ph;
    endtask

    // R2, R6: bench model takes the staged pair at each period start.
    task automatic push(input bit b);
        int re, im;
        step();
        if (m_cnt == 0) begin
            m_ph   = stg_ph;
            m_rate = stg_rate;
        end
        expect_of(m_ph, b, re, im);
        fill_re[fill_idx] = re;
        fill_im[fill_idx] = im;
        m_ph  = m_ph + m_rate;
        m_cnt = (m_cnt + 1) % MLEN;
        in_valid  = 1'b1;
        in_bit    = b;
        last_flag = (fill_idx == FLEN - 1);
        fill_idx++;
        if (fill_idx == FLEN) begin
            for (int k = 0; k < FLEN; k++) begin
                done_re[k] = fill_re[k];
                done_im[k] = fill_im[k];
            end
            fill_idx = 0;
        end
    endtask

    task automatic cmp(input int act, input int exp_v, input string what);
        checks++;
        if (act - exp_v > 1 || exp_v - act > 1) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp_v);
        end
    endtask

    // R7, R9: read the filled bank, one address per cycle, data one edge later.
    task automatic read_check();
        int re, im;
        for (int a = 0; a <= FLEN; a++) begin
            step();
            if (a > 0) begin
                re = int'($signed(rd_data[31:16]));
                im = int'($signed(rd_data[15:0]));
                cmp(re, done_re[a-1], "R1 R4 R7 R9 real part");
                cmp(im, done_im[a-1], "R2 R3 R4 imag part");
                checks++;
                if (re < -16384 || re > 16384 || im < -16384 || im > 16384) begin
                    fails++;
                    $display("FAIL R11 range actual=%0d/%0d expected=within +/-16384", re, im);
                end
            end
            if (a < FLEN) rd_addr = a[FAW-1:0];
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        checks++;
        if (frame_ready !== 1'b0) begin
            fails++;
            $display("FAIL R10 frame_ready actual=%b expected=0", frame_ready);
        end
        checks++;
        if (rd_data !== 32'h0) begin
            fails++;
            $display("FAIL R10 rd_data actual=%h expected=0", rd_data);
        end
        rst_n = 1'b1;

        // Sweep A: unit table step, every 14-bit phase once (R1..R4, R11).
        for (int p = 0; p < 256; p++) begin
            load(32'h0004_0000, 32'(p) << 24);
            for (int f = 0; f < MF; f++) begin
                for (int i = 0; i < FLEN; i++) push(($urandom() % 2) == 1);
                repeat (4) step();
                read_check();
            end
        end

        // Sweep B: random models, idle gaps (R5), mid-period loads (R6),
        // reads of the previous frame while the next one fills (R7).
        load($urandom(), $urandom());
        for (int p = 0; p < 64; p++) begin
            for (int f = 0; f < MF; f++) begin
                for (int i = 0; i < FLEN; i++) begin
                    repeat ($urandom() % 3) step();
                    push(($urandom() % 2) == 1);
                    if (i == 7) read_check();
                    if (f == 1 && i == FLEN - 1) load($urandom(), $urandom());
                end
            end
        end
        repeat (4) step();
        read_check();

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R8 actual=hung expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule